// File: doc/BRIEF.md
# Cached DRAM row-hit controller

This block is a cycle-based model of the control path of a DRAM whose four internal banks each carry a one-row cache. When the row-enable strobe falls, it latches the address, picks a bank from two address bits and compares the row against that bank's stored row tag. It then classifies the access as a read or a write, and as a hit or a miss. It drives an active-low hit flag, together with a separate enable that shows when the flag is being driven.

Its other outputs steer a DRAM array model and a cache array model. These are a DRAM write strobe, a cache write strobe, a cache row-load pulse, the bank whose cached row is visible, and the data-output enable.

A read miss reloads the bank's tag, and the cache row is then refilled. A write hit updates the DRAM and the cache together. A write miss goes to the DRAM only. It blanks the data outputs while the cycle lasts and for a set number of clocks after row-enable rises. Refresh cycles and deselected cycles do not classify anything.

Top module: `cdram_hit_ctrl`

## Requirements
- R1: At a falling edge of `re_n`, `addr[9:8]` selects the bank and `addr[8:0]` is compared with that bank's tag. After reset every tag is invalid, so the first read of any bank gives `hit_n`=1 one clock after the edge.
- R2: A read cycle (`wr_sel`=0, `cs_n`=0, `ref_n`=1 at the fall) that misses reloads only the selected bank's tag and pulses `cache_load` for one clock. A later read of the same row in that bank gives `hit_n`=0, and the tags of the other banks are unchanged.
- R3: A read hit and every write cycle leave all tags unchanged. A write to an uncached row does not make a later read of that row hit.
- R4: A write cycle starts only when `re_n` falls with `wr_sel`, `cal_n`, `we_n` and `ref_n` all high and `cs_n` low. A write cycle shows `cyc_wr`=1 and `hit_oe`=1. A fall with `we_n` low is not classified.
- R5: In a write hit `hit_n` is 0, and each write strobe (`cal_n`=0 and `we_n`=0) asserts both `dram_wr` and `cache_wr`.
- R6: In a write miss `hit_n` is 1, `cache_wr` stays 0 and `dq_oe` stays 0. The outputs remain blanked for WRR_CYC clocks after the clock edge that sees `re_n` high.
- R7: During an active write cycle `dq_oe` is 0 while `we_n` is low. In a write hit it follows `oe_n` (low means enabled) while `we_n` is high.
- R8: `dram_wr` is 1 only while a write cycle is active and both `cal_n` and `we_n` are low.
- R9: With `re_n` high, `hit_oe` is 0. `cache_bank` then gives the bank of the most recent read cycle, which is 0 after reset.
- R10: A fall of `re_n` with `ref_n` low is a refresh cycle. It is not classified, gives `hit_oe`=0, leaves the tags unchanged and produces no write.
- R11: A fall of `re_n` with `cs_n` high and `ref_n` high is ignored: no classification, no tag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| re_n | input | 1 | Row enable, active low; its fall starts a cycle |
| cal_n | input | 1 | Column latch strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ref_n | input | 1 | Refresh request, active low, sampled at the row-enable fall |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_sel | input | 1 | 1 = write request, 0 = read request |
| addr | input | 10 | Multiplexed address; the row is used at the fall |
| hit_n | output | 1 | Hit flag, 0 = hit, 1 = miss; meaningful when hit_oe is 1 |
| hit_oe | output | 1 | 1 while a classified read or write cycle is active (flag driven) |
| cyc_wr | output | 1 | 1 while the active cycle is a write |
| dq_oe | output | 1 | Data output enable |
| dram_wr | output | 1 | Write strobe to the DRAM array |
| cache_wr | output | 1 | Write strobe to the cache row of the current bank |
| cache_load | output | 1 | One-clock pulse: refill the bank's cache row from DRAM |
| cache_bank | output | 2 | Bank whose cached row is currently addressed |

## Verification
A tag that is stale, lost or written into the wrong bank shows at `hit_n` one clock after the next row-enable fall in the affected bank. That fall can come long after the corruption. For this reason the random phase keeps each bank's row set small, so every bank is revisited within a few cycles. A blanking counter that is loaded wrongly shows at `dq_oe` within WRR_CYC+1 clocks after a write miss ends. A wrong last-read bank shows at `cache_bank` on the first idle clock.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_REFR  = 2'd3
    } cyc_e;
endpackage

// File: rtl/cdram_row_tags.sv
module cdram_row_tags #(
    parameter int TAG_W  = 9,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lookup_bank,
    input  logic [TAG_W-1:0]  lookup_tag,
    input  logic              load_en,
    output logic              hit
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] match;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             valid_q;
        logic [TAG_W-1:0] tag_q;
        logic             sel;

        assign sel = load_en && (lookup_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                tag_q   <= '0;
            end else if (sel) begin
                valid_q <= 1'b1;
                tag_q   <= lookup_tag;
            end
        end

        assign match[b] = valid_q && (tag_q == lookup_tag);
    end

    assign hit = match[lookup_bank];
endmodule

// File: rtl/cdram_blank_timer.sv
module cdram_blank_timer #(
    parameter int WRR_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(WRR_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(WRR_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/cdram_hit_ctrl.sv
module cdram_hit_ctrl
    import cdram_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int TAG_W    = 9,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 8,
    parameter int WRR_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re_n,
    input  logic              cal_n,
    input  logic              we_n,
    input  logic              ref_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_n,
    output logic              hit_oe,
    output logic              cyc_wr,
    output logic              dq_oe,
    output logic              dram_wr,
    output logic              cache_wr,
    output logic              cache_load,
    output logic [BANK_W-1:0] cache_bank
);
    typedef struct packed {
        cyc_e              cyc;
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [BANK_W-1:0] last_rd_bank;
        logic              re_prev;
        logic              load;
    } state_t;

    state_t st_d, st_q;

    logic              re_fall, re_rise;
    logic [BANK_W-1:0] cur_bank;
    logic [TAG_W-1:0]  cur_tag;
    logic              tag_hit;
    logic              rd_start;
    logic              tag_load;
    logic              blank_start;
    logic              blank_busy;
    logic              wr_miss;

    assign re_fall  = st_q.re_prev && !re_n;
    assign re_rise  = !st_q.re_prev && re_n;
    assign cur_bank = addr[BANK_LSB +: BANK_W];
    assign cur_tag  = addr[TAG_W-1:0];
    assign rd_start = re_fall && ref_n && !cs_n && !wr_sel;
    assign tag_load = rd_start && !tag_hit;

    cdram_row_tags #(
        .TAG_W (TAG_W),
        .BANK_W(BANK_W)
    ) u_tags (
        .clk        (clk),
        .rst        (rst),
        .lookup_bank(cur_bank),
        .lookup_tag (cur_tag),
        .load_en    (tag_load),
        .hit        (tag_hit)
    );

    assign blank_start = re_rise && (st_q.cyc == CYC_WRITE) && !st_q.hit;

    cdram_blank_timer #(
        .WRR_CYC(WRR_CYC)
    ) u_blank (
        .clk  (clk),
        .rst  (rst),
        .start(blank_start),
        .busy (blank_busy)
    );

    always_comb begin
        st_d         = st_q;
        st_d.re_prev = re_n;
        st_d.load    = 1'b0;
        if (re_fall) begin
            st_d.bank = cur_bank;
            st_d.hit  = tag_hit;
            if (!ref_n) begin
                st_d.cyc = CYC_REFR;
            end else if (cs_n) begin
                st_d.cyc = CYC_IDLE;
            end else if (wr_sel) begin
                st_d.cyc = (cal_n && we_n) ? CYC_WRITE : CYC_IDLE;
            end else begin
                st_d.cyc          = CYC_READ;
                st_d.last_rd_bank = cur_bank;
                st_d.load         = !tag_hit;
            end
        end else if (re_n) begin
            st_d.cyc = CYC_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cyc          <= CYC_IDLE;
            st_q.hit          <= 1'b0;
            st_q.bank         <= '0;
            st_q.last_rd_bank <= '0;
            st_q.re_prev      <= 1'b1;
            st_q.load         <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_oe     = (st_q.cyc == CYC_READ) || (st_q.cyc == CYC_WRITE);
    assign hit_n      = hit_oe ? !st_q.hit : 1'b1;
    assign cyc_wr     = (st_q.cyc == CYC_WRITE);
    assign wr_miss    = cyc_wr && !st_q.hit;
    assign dram_wr    = cyc_wr && !cal_n && !we_n;
    assign cache_wr   = dram_wr && st_q.hit;
    assign cache_load = st_q.load;
    assign cache_bank = hit_oe ? st_q.bank : st_q.last_rd_bank;
    assign dq_oe      = !oe_n && !cs_n && !wr_miss && !blank_busy
                        && !(cyc_wr && !we_n);
endmodule

// File: rtl/cdram_hit_ctrl_chk.sv
module cdram_hit_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic re_n,
    input logic cal_n,
    input logic we_n,
    input logic hit_n,
    input logic hit_oe,
    input logic cyc_wr,
    input logic dq_oe,
    input logic dram_wr,
    input logic cache_wr,
    input logic cache_load
);
    // R8
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dram_wr |-> (!cal_n && !we_n && cyc_wr && hit_oe));

    // R5
    cache_wr_chk: assert property (@(posedge clk) disable iff (rst)
        cache_wr |-> (dram_wr && !hit_n));

    // R6
    wmiss_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_oe && cyc_wr && hit_n) |-> (!dq_oe && !cache_wr));

    // R6
    wmiss_tail_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(hit_oe) && $past(cyc_wr && hit_n)) |-> !dq_oe);

    // R7
    wr_dq_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_wr && !we_n) |-> !dq_oe);

    // R9
    idle_hitz_chk: assert property (@(posedge clk) disable iff (rst)
        $past(re_n) |-> !hit_oe);

    // R2
    load_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        cache_load |-> (hit_oe && hit_n && !cyc_wr));

    // R2
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cache_load |=> !cache_load);
endmodule

bind cdram_hit_ctrl cdram_hit_ctrl_chk u_chk (.*);

// File: tb/cdram_hit_ctrl_test.sv
module cdram_hit_ctrl_test;
    localparam int WRR = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       re_n, cal_n, we_n, ref_n, cs_n, oe_n, wr_sel;
    logic [9:0] addr;
    logic       hit_n, hit_oe, cyc_wr, dq_oe, dram_wr, cache_wr, cache_load;
    logic [1:0] cache_bank;

    int checks = 0;
    int fails  = 0;

    bit         m_valid [4];
    logic [8:0] m_tag   [4];
    int         m_last_bank;

    always #10 clk = ~clk;

    cdram_hit_ctrl #(.WRR_CYC(WRR)) uut (
        .clk(clk), .rst(rst), .re_n(re_n), .cal_n(cal_n), .we_n(we_n),
        .ref_n(ref_n), .cs_n(cs_n), .oe_n(oe_n), .wr_sel(wr_sel), .addr(addr),
        .hit_n(hit_n), .hit_oe(hit_oe), .cyc_wr(cyc_wr), .dq_oe(dq_oe),
        .dram_wr(dram_wr), .cache_wr(cache_wr), .cache_load(cache_load),
        .cache_bank(cache_bank)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_hit(logic [9:0] a);
        return m_valid[a[9:8]] && (m_tag[a[9:8]] == a[8:0]);
    endfunction

    task automatic idle_inputs();
        re_n = 1'b1; cal_n = 1'b1; we_n = 1'b1; ref_n = 1'b1;
        cs_n = 1'b0; oe_n = 1'b0; wr_sel = 1'b0;
    endtask

    task automatic read_cycle(logic [9:0] a, string req);
        bit h;
        @(negedge clk);
        idle_inputs();
        addr = a; re_n = 1'b0;
        h = exp_hit(a);
        @(negedge clk);
        chk(req, "read hit_n", int'(hit_n), int'(!h));
        chk("R2", "read cache_load", int'(cache_load), int'(!h));
        chk("R1", "read hit_oe/bank", int'({hit_oe, cyc_wr, cache_bank}), int'({2'b10, a[9:8]}));
        if (!h) begin
            m_valid[a[9:8]] = 1'b1;
            m_tag[a[9:8]]   = a[8:0];
        end
        m_last_bank = int'(a[9:8]);
        re_n = 1'b1;
        @(negedge clk);
        chk("R9", "idle hit_oe/cache_bank", int'({hit_oe, cache_bank}), m_last_bank);
    endtask

    task automatic write_cycle(logic [9:0] a, bit strobe);
        bit h;
        @(negedge clk);
        idle_inputs();
        addr = a; wr_sel = 1'b1; re_n = 1'b0;
        h = exp_hit(a);
        @(negedge clk);
        chk(h ? "R5" : "R6", "write hit_n", int'(hit_n), int'(!h));
        chk("R4", "write hit_oe/cyc_wr", int'({hit_oe, cyc_wr}), 3);
        chk("R7", "write dq_oe we_n high", int'(dq_oe), int'(h));
        cal_n = !strobe;
        #1;
        chk("R8", "dram_wr with we_n high", int'(dram_wr), 0);
        we_n = 1'b0;
        #1;
        chk("R8", "dram_wr strobe", int'(dram_wr), int'(strobe));
        chk(h ? "R5" : "R6", "cache_wr strobe", int'(cache_wr), int'(strobe && h));
        chk("R7", "dq_oe we_n low", int'(dq_oe), 0);
        @(negedge clk);
        cal_n = 1'b1; we_n = 1'b1; re_n = 1'b1;
        #1;
        chk("R8", "dram_wr released", int'(dram_wr), 0);
        if (!h) begin
            for (int i = 0; i < WRR; i++) begin
                @(negedge clk);
                chk("R6", "blank after write miss", int'(dq_oe), 0);
            end
        end
        @(negedge clk);
        chk(h ? "R7" : "R6", "dq_oe after write", int'(dq_oe), 1);
        chk("R9", "idle after write", int'({hit_oe, cache_bank}), m_last_bank);
    endtask

    task automatic ignored_cycle(logic [9:0] a, logic rf, logic cs, logic wr, logic we, string req);
        @(negedge clk);
        idle_inputs();
        addr = a; ref_n = rf; cs_n = cs; wr_sel = wr; we_n = we; re_n = 1'b0;
        @(negedge clk);
        chk(req, "unclassified hit_oe/cyc_wr", int'({hit_oe, cyc_wr}), 0);
        chk(req, "unclassified cache_load", int'(cache_load), 0);
        cal_n = 1'b0; we_n = 1'b0;
        #1;
        chk(req, "unclassified dram_wr/cache_wr", int'({dram_wr, cache_wr}), 0);
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 4; b++) begin
            m_valid[b] = 1'b0;
            m_tag[b]   = '0;
        end
        m_last_bank = 0;
        idle_inputs();
        oe_n = 1'b1;
        addr = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "reset hit_oe/cache_bank", int'({hit_oe, cache_bank}), 0);
        chk("R8", "reset strobes", int'({dram_wr, cache_wr, cache_load}), 0);
        chk("R7", "reset dq_oe oe_n high", int'(dq_oe), 0);

        // R1 R2: first access misses, repeat hits, banks independent
        read_cycle(10'h000, "R1");
        read_cycle(10'h000, "R2");
        read_cycle(10'h100, "R1");
        read_cycle(10'h000, "R2");
        read_cycle(10'h2A5, "R1");
        // R5 write hit with strobe
        write_cycle(10'h000, 1'b1);
        // R6 write miss; R3 a write does not load the tag
        write_cycle(10'h005, 1'b1);
        read_cycle(10'h005, "R3");
        read_cycle(10'h000, "R3");
        // R8 write cycle without column strobe
        write_cycle(10'h000, 1'b0);
        // R10 refresh, R11 deselected, R4 bad write start
        ignored_cycle(10'h0FF, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        ignored_cycle(10'h0FF, 1'b1, 1'b1, 1'b0, 1'b1, "R11");
        ignored_cycle(10'h0FF, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        read_cycle(10'h000, "R10");
        // R9 last read bank survives a write to another bank
        read_cycle(10'h2A5, "R9");
        write_cycle(10'h3C3, 1'b1);

        for (int n = 0; n < 200; n++) begin
            logic [9:0] a;
            a = {2'($urandom % 4), 6'd0, 2'($urandom % 3)};
            case ($urandom % 4)
                0, 1: read_cycle(a, "R2");
                2:    write_cycle(a, 1'($urandom % 2));
                default: ignored_cycle(a, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule